// File: doc/BRIEF.md
# Packet Timestamp Capture Latch Bank

This block sits beside a running 64-bit nanosecond counter and freezes its value whenever the packet path flags a timing event. A single transmit slot serves outgoing event packets. Incoming event packets draw from a small pool of receive slots. Each slot holds its value and stays locked until software reads its upper word. Software may also write that word at configuration time to unlatch the slot. A read of the lower word leaves the lock alone, so software can read the low half first and then the high half.

When a receive capture succeeds, the block pulses a capture flag together with the index of the slot it used. The packet path stores that index in the receive descriptor. When every receive slot is locked, the event is not stored and a one-cycle drop flag pulses in place of the index. A level interrupt reports a held transmit timestamp, gated by an enable bit in the control register. Register reads return data combinationally in the same cycle. Side effects of an access, such as a release or a control update, take hold at the next clock edge.

Top module: `tscap_bank`

## Requirements
- R1: After reset, all valid bits, the interrupt enable, irq_o, rx_cap_o and rx_drop_o are 0. Reads of control (address 0), transmit status (address 1) and receive status (address 2) return 0.
- R2: A receive event takes the lowest-numbered slot whose valid bit was clear before the edge. It stores time_ns from the event cycle. In the next cycle rx_cap_o pulses for one cycle with rx_idx_o equal to that slot.
- R3: Bits 0 to 3 of the receive status word (address 2) are the valid bits of receive slots 0 to 3. Bit 0 of the transmit status word (address 1) is the transmit valid bit.
- R4: Receive slot i has its low word at address 8+2i and its high word at address 9+2i. Reading the high word of a slot releases that slot and clears its valid bit from the next cycle. Reading the low word changes nothing.
- R5: A receive event that arrives while all four receive slots are valid stores nothing and leaves every slot unchanged. It pulses rx_drop_o for one cycle instead of rx_cap_o.
- R6: A transmit event stores time_ns in the transmit slot only when that slot is free. The slot's low word is at address 3 and its high word at address 4. An event that arrives while the slot is locked is ignored. Reading address 4 releases the slot.
- R7: irq_o is high exactly when the transmit valid bit and the interrupt enable are both set. The interrupt enable is bit 0 of the control word at address 0, which a write sets or clears.
- R8: Writing the high-word address of any slot, receive or transmit, releases that slot exactly as a read of that address does.
- R9: If a high-word access and a new event hit the same cycle, the release wins. The released slot is not refilled in that cycle, so with no other slot free the receive event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | 64 | Running nanosecond time |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (same cycle) |
| rx_cap_o | output | 1 | Receive capture pulse |
| rx_idx_o | output | 2 | Slot used by the receive capture |
| rx_drop_o | output | 1 | Receive event dropped pulse |
| irq_o | output | 1 | Transmit timestamp interrupt |

## Verification
The assertions assume that each access strobe is paired with a meaningful address. They also assume that a read and a write of the same high-word address in one cycle count as one release. In that case they treat rd_en or wr_en as a single access. The stimulus never raises rd_en and wr_en together, and it drives addresses only across the 4-bit map, so undecoded addresses are exercised as reads of zero. Events, reads and writes are mixed freely in the same cycle so that the release-first ordering is reached often.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
    // Fixed word addresses of the register map
    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_TXSTAT = 1;
    localparam int unsigned ADDR_RXSTAT = 2;
    localparam int unsigned ADDR_TXLO   = 3;
    localparam int unsigned ADDR_TXHI   = 4;
    localparam int unsigned ADDR_RXBASE = 8;
endpackage

// File: rtl/tscap_pick.sv
module tscap_pick #(
    parameter int unsigned N     = 4,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest free slot is the last one written
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tscap_hidec.sv
module tscap_hidec
    import tscap_pkg::*;
#(
    parameter int unsigned N      = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              acc,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      rx_rel,
    output logic              tx_rel
);
    assign tx_rel = acc && (addr == ADDR_W'(ADDR_TXHI));

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign rx_rel[g] = acc && (addr == ADDR_W'(ADDR_RXBASE + 2 * g + 1));
    end
endmodule

// File: rtl/tscap_rmux.sv
module tscap_rmux
    import tscap_pkg::*;
#(
    parameter int unsigned N      = 4,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned TIME_W = 2 * WORD_W
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     irq_en,
    input  logic                     tx_vld,
    input  logic [TIME_W-1:0]        tx_ts,
    input  logic [N-1:0]             rx_vld,
    input  logic [N-1:0][TIME_W-1:0] rx_ts,
    output logic [WORD_W-1:0]        rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL))   rdata = WORD_W'(irq_en);
        if (addr == ADDR_W'(ADDR_TXSTAT)) rdata = WORD_W'(tx_vld);
        if (addr == ADDR_W'(ADDR_RXSTAT)) rdata = WORD_W'(rx_vld);
        if (addr == ADDR_W'(ADDR_TXLO))   rdata = tx_ts[WORD_W-1:0];
        if (addr == ADDR_W'(ADDR_TXHI))   rdata = tx_ts[TIME_W-1:WORD_W];
        for (int i = 0; i < N; i++) begin
            if (addr == ADDR_W'(ADDR_RXBASE + 2 * i))     rdata = rx_ts[i][WORD_W-1:0];
            if (addr == ADDR_W'(ADDR_RXBASE + 2 * i + 1)) rdata = rx_ts[i][TIME_W-1:WORD_W];
        end
    end
endmodule

// File: rtl/tscap_bank.sv
module tscap_bank
    import tscap_pkg::*;
#(
    parameter int unsigned RX_SLOTS = 4,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    localparam int unsigned TIME_W  = 2 * WORD_W,
    localparam int unsigned IDX_W   = (RX_SLOTS > 1) ? $clog2(RX_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_ns,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rx_cap_o,
    output logic [IDX_W-1:0]  rx_idx_o,
    output logic              rx_drop_o,
    output logic              irq_o
);
    typedef struct packed {
        logic                            irq_en;
        logic                            tx_vld;
        logic [TIME_W-1:0]               tx_ts;
        logic [RX_SLOTS-1:0]             rx_vld;
        logic [RX_SLOTS-1:0][TIME_W-1:0] rx_ts;
        logic                            rx_cap;
        logic [IDX_W-1:0]                rx_idx;
        logic                            rx_drop;
    } state_t;

    state_t st_d, st_q;

    logic                acc_w;
    logic [RX_SLOTS-1:0] rx_rel_w;
    logic                tx_rel_w;
    logic                pick_found_w;
    logic [IDX_W-1:0]    pick_idx_w;
    logic                irq_en_w;
    logic                tx_vld_w;
    logic [RX_SLOTS-1:0] rx_vld_w;

    assign acc_w = rd_en || wr_en;

    tscap_hidec #(.N(RX_SLOTS), .ADDR_W(ADDR_W)) hidec_i (
        .acc    (acc_w),
        .addr   (addr),
        .rx_rel (rx_rel_w),
        .tx_rel (tx_rel_w)
    );

    // Allocation looks at the valid bits before any release of this cycle
    tscap_pick #(.N(RX_SLOTS)) pick_i (
        .busy  (st_q.rx_vld),
        .found (pick_found_w),
        .idx   (pick_idx_w)
    );

    tscap_rmux #(.N(RX_SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) rmux_i (
        .addr   (addr),
        .irq_en (st_q.irq_en),
        .tx_vld (st_q.tx_vld),
        .tx_ts  (st_q.tx_ts),
        .rx_vld (st_q.rx_vld),
        .rx_ts  (st_q.rx_ts),
        .rdata  (rdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rx_cap  = 1'b0;
        st_d.rx_drop = 1'b0;

        if (wr_en && addr == ADDR_W'(ADDR_CTRL)) begin
            st_d.irq_en = wdata[0];
        end

        // Transmit slot: a locked slot ignores new events
        if (st_q.tx_vld) begin
            if (tx_rel_w) st_d.tx_vld = 1'b0;
        end else if (tx_evt) begin
            st_d.tx_vld = 1'b1;
            st_d.tx_ts  = time_ns;
        end

        // Receive pool: release first, then fill a slot that was already free
        st_d.rx_vld = st_q.rx_vld & ~rx_rel_w;
        if (rx_evt) begin
            if (pick_found_w) begin
                st_d.rx_vld[pick_idx_w] = 1'b1;
                st_d.rx_ts[pick_idx_w]  = time_ns;
                st_d.rx_cap             = 1'b1;
                st_d.rx_idx             = pick_idx_w;
            end else begin
                st_d.rx_drop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_en_w  = st_q.irq_en;
    assign tx_vld_w  = st_q.tx_vld;
    assign rx_vld_w  = st_q.rx_vld;
    assign rx_cap_o  = st_q.rx_cap;
    assign rx_idx_o  = st_q.rx_idx;
    assign rx_drop_o = st_q.rx_drop;
    assign irq_o     = st_q.tx_vld && st_q.irq_en;
endmodule

// File: rtl/tscap_bank_chk.sv
module tscap_bank_chk
    import tscap_pkg::*;
#(
    parameter int unsigned RX_SLOTS = 4,
    parameter int unsigned ADDR_W   = 4,
    localparam int unsigned IDX_W   = (RX_SLOTS > 1) ? $clog2(RX_SLOTS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_evt,
    input logic                rx_evt,
    input logic                rd_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic                rx_cap_o,
    input logic [IDX_W-1:0]    rx_idx_o,
    input logic                rx_drop_o,
    input logic                irq_o,
    input logic                irq_en,
    input logic                tx_vld,
    input logic [RX_SLOTS-1:0] rx_vld
);
    function automatic logic [RX_SLOTS-1:0] low_mask(input logic [IDX_W-1:0] k);
        logic [RX_SLOTS-1:0] m;
        m = '0;
        for (int i = 0; i < RX_SLOTS; i++) if (i < int'(k)) m[i] = 1'b1;
        return m;
    endfunction

    logic tx_hi_acc;
    assign tx_hi_acc = (rd_en || wr_en) && addr == ADDR_W'(ADDR_TXHI);

    assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && (&rx_vld) |=> rx_drop_o && !rx_cap_o);

    assert_capture_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && !(&rx_vld) |=> rx_cap_o && !rx_drop_o);

    assert_lowest_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cap_o |-> ((($past(rx_vld) >> rx_idx_o) & RX_SLOTS'(1)) == '0)
                  && (($past(rx_vld) & low_mask(rx_idx_o)) == low_mask(rx_idx_o)));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en && tx_vld);

    assert_tx_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld && !tx_hi_acc |=> tx_vld);

    assert_tx_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld && tx_hi_acc |=> !tx_vld);

    for (genvar g = 0; g < RX_SLOTS; g++) begin : g_slot
        logic hi_acc;
        assign hi_acc = (rd_en || wr_en) && addr == ADDR_W'(ADDR_RXBASE + 2 * g + 1);

        assert_rx_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rx_vld[g] && !hi_acc |=> rx_vld[g]);

        assert_rx_release_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rx_vld[g] && hi_acc |=> !rx_vld[g]);

        assert_rx_set_by_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_vld[g]) |-> $past(rx_evt));
    end
endmodule

bind tscap_bank tscap_bank_chk #(.RX_SLOTS(RX_SLOTS), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_evt    (tx_evt),
    .rx_evt    (rx_evt),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rx_cap_o  (rx_cap_o),
    .rx_idx_o  (rx_idx_o),
    .rx_drop_o (rx_drop_o),
    .irq_o     (irq_o),
    .irq_en    (irq_en_w),
    .tx_vld    (tx_vld_w),
    .rx_vld    (rx_vld_w)
);

// File: tb/tscap_bank_tb.sv
`timescale 1ns/1ps
module tscap_bank_tb_top;
    localparam int CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] time_ns;
    logic        tx_evt, rx_evt, rd_en, wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rx_cap_o, rx_drop_o, irq_o;
    logic [1:0]  rx_idx_o;

    always #(CYC/2) clk = ~clk;

    tscap_bank dut_i (
        .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rx_cap_o(rx_cap_o), .rx_idx_o(rx_idx_o), .rx_drop_o(rx_drop_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    logic [3:0]  m_vld;
    logic [63:0] m_ts [4];
    logic        m_txv, m_en;
    logic [63:0] m_txts;
    logic        e_cap, e_drop;
    logic [1:0]  e_idx;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            4'd0: v = {31'b0, m_en};
            4'd1: v = {31'b0, m_txv};
            4'd2: v = {28'b0, m_vld};
            4'd3: v = m_txts[31:0];
            4'd4: v = m_txts[63:32];
            default: if (a >= 4'd8) v = a[0] ? m_ts[(a - 4'd8) >> 1][63:32]
                                            : m_ts[(a - 4'd8) >> 1][31:0];
        endcase
        return v;
    endfunction

    // One cycle: drive at negedge, check same-cycle read data, update model,
    // then check registered outputs at the following negedge.
    task automatic cyc(input bit t, input bit r, input bit rd, input bit wr,
                       input logic [3:0] a, input logic [31:0] wd, input string tag);
        logic [3:0] rel;
        logic       txrel;
        bit         got;
        tx_evt = t; rx_evt = r; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        time_ns = {$urandom, $urandom};
        #1;
        if (rd) chk(rdata == exp_rd(a), tag, rdata, exp_rd(a));
        for (int i = 0; i < 4; i++) rel[i] = (rd || wr) && a == 4'(9 + 2 * i);
        txrel = (rd || wr) && a == 4'd4;
        if (wr && a == 4'd0) m_en = wd[0];
        if (m_txv) begin
            if (txrel) m_txv = 1'b0;
        end else if (t) begin
            m_txv = 1'b1; m_txts = time_ns;
        end
        e_cap = 1'b0; e_drop = 1'b0; got = 1'b0;
        if (r) begin
            for (int i = 0; i < 4; i++) if (!got && !m_vld[i]) begin
                got = 1'b1; e_idx = 2'(i);
            end
        end
        m_vld = m_vld & ~rel;
        if (r) begin
            if (got) begin
                m_vld[e_idx] = 1'b1; m_ts[e_idx] = time_ns; e_cap = 1'b1;
            end else e_drop = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        chk(rx_cap_o == e_cap, {tag, " cap"}, rx_cap_o, e_cap);
        if (e_cap) chk(rx_idx_o == e_idx, {tag, " idx"}, rx_idx_o, e_idx);
        chk(rx_drop_o == e_drop, {tag, " drop"}, rx_drop_o, e_drop);
        chk(irq_o == (m_txv && m_en), "R7 irq", irq_o, m_txv && m_en);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 4'd0, 32'd0, "idle");
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1588_cafe));
        rst_n = 1'b0; tx_evt = 0; rx_evt = 0; rd_en = 0; wr_en = 0;
        addr = '0; wdata = '0; time_ns = '0;
        m_vld = '0; m_txv = 0; m_en = 0; m_txts = '0;
        for (int i = 0; i < 4; i++) m_ts[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        chk(irq_o == 0 && rx_cap_o == 0 && rx_drop_o == 0, "R1 outputs", {irq_o, rx_cap_o, rx_drop_o}, 0);
        cyc(0, 0, 1, 0, 4'd0, 0, "R1 ctrl");
        cyc(0, 0, 1, 0, 4'd1, 0, "R1 txstat");
        cyc(0, 0, 1, 0, 4'd2, 0, "R1 rxstat");

        // R2, R5: fill the pool in order, then overflow
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 4'd0, 0, "R2 fill");
        cyc(0, 1, 1, 0, 4'd2, 0, "R3 status full");
        cyc(0, 0, 1, 0, 4'd2, 0, "R5 status after drop");
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 4'(8 + i), 0, "R5 contents");

        // R4: low word read keeps the lock, high word read releases
        cyc(0, 0, 1, 0, 4'd10, 0, "R4 low read");
        cyc(0, 1, 0, 0, 4'd0, 0, "R4 still locked");
        cyc(0, 0, 1, 0, 4'd11, 0, "R4 high read");
        cyc(0, 0, 1, 0, 4'd2, 0, "R3 status after release");
        cyc(0, 1, 0, 0, 4'd0, 0, "R2 refill lowest");

        // R9: release and event in the same cycle
        cyc(0, 1, 1, 0, 4'd13, 0, "R9 same cycle");
        cyc(0, 0, 1, 0, 4'd2, 0, "R9 status");
        cyc(0, 1, 0, 0, 4'd0, 0, "R9 refill next cycle");

        // R6, R7: transmit slot and interrupt gating
        cyc(1, 0, 0, 0, 4'd0, 0, "R7 disabled");
        cyc(0, 0, 1, 0, 4'd1, 0, "R6 txstat");
        cyc(0, 0, 0, 1, 4'd0, 32'd1, "R7 enable");
        cyc(1, 0, 1, 0, 4'd3, 0, "R6 locked ignore");
        cyc(0, 0, 1, 0, 4'd3, 0, "R6 data kept");
        cyc(1, 0, 1, 0, 4'd4, 0, "R6 release wins");
        cyc(1, 0, 0, 0, 4'd0, 0, "R6 recapture");
        cyc(0, 0, 0, 1, 4'd0, 32'd0, "R7 disable");

        // R8: write high words to unlatch all slots
        cyc(0, 0, 0, 1, 4'd4, 32'hffff_ffff, "R8 tx clear");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 4'(9 + 2 * i), 32'h0, "R8 rx clear");
        cyc(0, 0, 1, 0, 4'd2, 0, "R8 rx status");
        cyc(0, 0, 1, 0, 4'd1, 0, "R8 tx status");

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            int op;
            bit t, r, rd, wr;
            op = $urandom_range(0, 9);
            t  = ($urandom_range(0, 4) == 0);
            r  = ($urandom_range(0, 2) == 0);
            rd = (op < 5);
            wr = (op == 5);
            cyc(t, r, rd, wr, 4'($urandom_range(0, 15)), $urandom, "R2 R4 R6 random");
        end
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule